// File: doc/BRIEF.md
# Overlapping Windowed Register File

This block is a register file for a processor core in which every instruction names one of 32 registers with a 5-bit specifier, while the storage behind those names is much larger. Eight specifiers always reach the same global registers. The other 24 reach a window of storage picked by a window pointer. The windows form a ring, and each window shares one group of eight registers with the window after it. Values placed in that shared group before a call can therefore be seen by the callee, and no copy is needed.

The file has two combinational read ports and one write port. A save command moves the pointer one window forward and a restore command moves it one window back, with wrap-around at both ends. A mask input marks windows that may not be entered. A save or restore aimed at a masked window does not move the pointer. It raises an overflow or an underflow trap for one cycle instead. Software handles the trap and does any spilling or refilling of register contents.

With `NWIN` windows the storage holds 8 + 16·`NWIN` registers of `DW` bits. In window k, specifiers 8–15 are the incoming group, 16–23 are the private locals and 24–31 are the outgoing group.

Top module: `winreg_file`

## Requirements
- R1: After a synchronous active-high reset the window pointer is 0, both trap outputs are low and every register reads as zero.
- R2: Specifiers 0–7 select global registers, and each of them refers to the same storage in every window.
- R3: Specifiers 16–23 select registers private to the current window. A write to one of them changes no register as seen from any other window.
- R4: Specifiers 24–31 of window k refer to the same storage as specifiers 8–15 of window (k+1) mod NWIN, and this includes the wrap from the last window to window 0.
- R5: A save whose target window (pointer+1 mod NWIN) has its mask bit clear sets the pointer to that window at the clock edge. The pointer does not change in any cycle without a save or restore.
- R6: A restore whose target window (pointer−1 mod NWIN) has its mask bit clear sets the pointer to that window at the clock edge, so a restore from window 0 lands on NWIN−1.
- R7: A save whose target window is masked leaves the pointer unchanged and raises the overflow trap for exactly the following cycle.
- R8: A restore whose target window is masked leaves the pointer unchanged and raises the underflow trap for exactly the following cycle. The two traps are never high together.
- R9: When save and restore are requested in the same cycle, only the save acts.
- R10: Both read ports are combinational. When a read selects the same register as a write in the same cycle, the read returns the data being written.
- R11: A write always lands in the window that is current at that clock edge, even when a save or restore moves the pointer at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rs_a | input | 5 | Specifier for read port A |
| rs_b | input | 5 | Specifier for read port B |
| rd_a | output | DW | Read data, port A |
| rd_b | output | DW | Read data, port B |
| wr_en | input | 1 | Write enable |
| wr_spec | input | 5 | Write specifier |
| wr_data | input | DW | Write data |
| save_req | input | 1 | Move to the next window |
| restore_req | input | 1 | Move to the previous window |
| inval_mask | input | NWIN | One bit per window; a set bit forbids entry |
| cur_win | output | CW | Current window pointer |
| ovf_trap | output | 1 | Overflow trap pulse |
| unf_trap | output | 1 | Underflow trap pulse |

## Verification
The hardest case to reach is aliasing across the wrap. The outgoing group of the last window must be the incoming group of window 0, and no local register may leak into a neighbour. To get there, the stimulus fills every specifier of every window with a value that encodes both the window and the specifier, using saves to walk all the way round the ring. It then walks the ring again and reads all 32 specifiers in each window on both ports. A bench-side model of the storage predicts each value, with later overlapping writes overwriting earlier ones. Separate directed steps cover a write issued in the same cycle as a save, and saves and restores that target a masked window.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

    localparam int unsigned SPEC_W   = 5;
    localparam int unsigned N_GLOBAL = 8;
    localparam int unsigned GRP_SZ   = 8;
    localparam int unsigned WIN_OWN  = 2 * GRP_SZ;

    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_IN     = 2'd1,
        GRP_LOCAL  = 2'd2,
        GRP_OUT    = 2'd3
    } grp_e;

    typedef enum logic [1:0] {
        CMD_NONE    = 2'd0,
        CMD_SAVE    = 2'd1,
        CMD_RESTORE = 2'd2
    } win_cmd_e;

    // Storage layout: globals first, then per window its locals followed by
    // its outgoing group. The incoming group lives in the previous window's slot.
    function automatic int unsigned phys_index(input int unsigned nwin,
                                               input int unsigned cwp,
                                               input logic [SPEC_W-1:0] spec);
        grp_e        grp;
        int unsigned off;
        int unsigned prev;
        grp  = grp_e'(spec[4:3]);
        off  = int'(spec[2:0]);
        prev = (cwp == 0) ? nwin - 1 : cwp - 1;
        case (grp)
            GRP_GLOBAL: phys_index = off;
            GRP_IN:     phys_index = N_GLOBAL + WIN_OWN * prev + GRP_SZ + off;
            GRP_LOCAL:  phys_index = N_GLOBAL + WIN_OWN * cwp + off;
            default:    phys_index = N_GLOBAL + WIN_OWN * cwp + GRP_SZ + off;
        endcase
    endfunction

endpackage

// File: rtl/wrf_map.sv
module wrf_map #(
    parameter int NWIN = 8,
    parameter int CW   = 3,
    parameter int PW   = 8
) (
    input  logic [CW-1:0]                 cwp,
    input  logic [wrf_pkg::SPEC_W-1:0]    spec,
    output logic [PW-1:0]                 phys
);
    always_comb begin
        phys = PW'(wrf_pkg::phys_index(NWIN, int'(cwp), spec));
    end
endmodule

// File: rtl/wrf_window_ctl.sv
module wrf_window_ctl #(
    parameter int NWIN = 8,
    parameter int CW   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  wrf_pkg::win_cmd_e  cmd,
    input  logic [NWIN-1:0]    inval_mask,
    output logic [CW-1:0]      cwp,
    output logic               ovf,
    output logic               unf
);
    localparam logic [CW-1:0] LAST_WIN = CW'(NWIN - 1);

    logic [CW-1:0] nxt_win;
    logic [CW-1:0] prv_win;

    always_comb begin
        nxt_win = (cwp == LAST_WIN) ? '0 : cwp + 1'b1;
        prv_win = (cwp == '0) ? LAST_WIN : cwp - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp <= '0;
            ovf <= 1'b0;
            unf <= 1'b0;
        end else begin
            ovf <= 1'b0;
            unf <= 1'b0;
            case (cmd)
                wrf_pkg::CMD_SAVE: begin
                    if (inval_mask[nxt_win]) ovf <= 1'b1;
                    else                     cwp <= nxt_win;
                end
                wrf_pkg::CMD_RESTORE: begin
                    if (inval_mask[prv_win]) unf <= 1'b1;
                    else                     cwp <= prv_win;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
    parameter int DW    = 32,
    parameter int NPHYS = 136,
    parameter int PW    = 8,
    parameter int NRD   = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [PW-1:0]            waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [NRD-1:0][PW-1:0]   raddr,
    output logic [NRD-1:0][DW-1:0]   rdata
);
    logic [DW-1:0] regs [NPHYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPHYS; i++) regs[i] <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = (we && (waddr == raddr[p])) ? wdata : regs[raddr[p]];
    end
endmodule

// File: rtl/winreg_file.sv
module winreg_file #(
    parameter int NWIN = 8,
    parameter int DW   = 32,
    localparam int CW    = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int NPHYS = wrf_pkg::N_GLOBAL + wrf_pkg::WIN_OWN * NWIN,
    localparam int PW    = $clog2(NPHYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        rs_a,
    input  logic [4:0]        rs_b,
    output logic [DW-1:0]     rd_a,
    output logic [DW-1:0]     rd_b,
    input  logic              wr_en,
    input  logic [4:0]        wr_spec,
    input  logic [DW-1:0]     wr_data,
    input  logic              save_req,
    input  logic              restore_req,
    input  logic [NWIN-1:0]   inval_mask,
    output logic [CW-1:0]     cur_win,
    output logic              ovf_trap,
    output logic              unf_trap
);
    localparam int NMAP = 3;

    wrf_pkg::win_cmd_e       cmd;
    logic [NMAP-1:0][4:0]    spec_all;
    logic [NMAP-1:0][PW-1:0] phys_all;
    logic [1:0][PW-1:0]      raddr;
    logic [1:0][DW-1:0]      rdata;

    always_comb begin
        if (save_req)         cmd = wrf_pkg::CMD_SAVE;
        else if (restore_req) cmd = wrf_pkg::CMD_RESTORE;
        else                  cmd = wrf_pkg::CMD_NONE;
    end

    assign spec_all = {wr_spec, rs_b, rs_a};

    wrf_window_ctl #(.NWIN(NWIN), .CW(CW)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .inval_mask (inval_mask),
        .cwp        (cur_win),
        .ovf        (ovf_trap),
        .unf        (unf_trap)
    );

    for (genvar m = 0; m < NMAP; m++) begin : g_map
        wrf_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_map (
            .cwp  (cur_win),
            .spec (spec_all[m]),
            .phys (phys_all[m])
        );
    end

    assign raddr = {phys_all[1], phys_all[0]};

    wrf_storage #(.DW(DW), .NPHYS(NPHYS), .PW(PW), .NRD(2)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .waddr (phys_all[2]),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (rdata)
    );

    assign rd_a = rdata[0];
    assign rd_b = rdata[1];
endmodule

// File: rtl/wrf_checks.sv
module wrf_checks #(
    parameter int NWIN = 8,
    parameter int DW   = 32,
    parameter int CW   = 3
) (
    input logic            clk,
    input logic            rst,
    input logic [4:0]      rs_a,
    input logic [DW-1:0]   rd_a,
    input logic            wr_en,
    input logic [4:0]      wr_spec,
    input logic [DW-1:0]   wr_data,
    input logic            save_req,
    input logic            restore_req,
    input logic [NWIN-1:0] inval_mask,
    input logic [CW-1:0]   cur_win,
    input logic            ovf_trap,
    input logic            unf_trap
);
    logic [CW-1:0] up_w;
    logic [CW-1:0] dn_w;

    always_comb begin
        up_w = (int'(cur_win) == NWIN - 1) ? '0 : CW'(int'(cur_win) + 1);
        dn_w = (cur_win == '0) ? CW'(NWIN - 1) : CW'(int'(cur_win) - 1);
    end

    // R5
    save_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (save_req && !inval_mask[up_w]) |=> (cur_win == $past(up_w)));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!save_req && !restore_req) |=> $stable(cur_win));

    // R6
    restore_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (restore_req && !save_req && !inval_mask[dn_w]) |=> (cur_win == $past(dn_w)));

    // R7
    overflow_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (save_req && inval_mask[up_w]) |=> (ovf_trap && $stable(cur_win)));

    // R8
    underflow_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (restore_req && !save_req && inval_mask[dn_w]) |=> (unf_trap && $stable(cur_win)));

    // R8
    no_dual_trap_chk: assert property (@(posedge clk) disable iff (rst)
        !(ovf_trap && unf_trap));

    // R9
    save_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (save_req && restore_req) |=> !unf_trap);

    // R10
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_spec == rs_a)) |-> (rd_a == wr_data));
endmodule

bind winreg_file wrf_checks #(.NWIN(NWIN), .DW(DW), .CW(CW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rs_a        (rs_a),
    .rd_a        (rd_a),
    .wr_en       (wr_en),
    .wr_spec     (wr_spec),
    .wr_data     (wr_data),
    .save_req    (save_req),
    .restore_req (restore_req),
    .inval_mask  (inval_mask),
    .cur_win     (cur_win),
    .ovf_trap    (ovf_trap),
    .unf_trap    (unf_trap)
);

// File: tb/sim_winreg_file.sv
module sim_winreg_file;
    localparam int NW  = 4;
    localparam int DW  = 32;
    localparam int CW  = 2;
    localparam int NPH = 8 + 16 * NW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [4:0]    rs_a = '0, rs_b = '0, wr_spec = '0;
    logic [DW-1:0] rd_a, rd_b, wr_data = '0;
    logic          wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0;
    logic [NW-1:0] inval_mask = '0;
    logic [CW-1:0] cur_win;
    logic          ovf_trap, unf_trap;

    int            n_chk = 0;
    int            n_fail = 0;
    logic [DW-1:0] model [NPH];
    int            bw = 0;

    always #10 clk = ~clk;

    winreg_file #(.NWIN(NW), .DW(DW)) u0 (
        .clk(clk), .rst(rst), .rs_a(rs_a), .rs_b(rs_b), .rd_a(rd_a), .rd_b(rd_b),
        .wr_en(wr_en), .wr_spec(wr_spec), .wr_data(wr_data),
        .save_req(save_req), .restore_req(restore_req), .inval_mask(inval_mask),
        .cur_win(cur_win), .ovf_trap(ovf_trap), .unf_trap(unf_trap)
    );

    function automatic int bmap(int w, int s);
        if (s < 8)       return s;
        else if (s < 16) return 8 + 16 * ((w + NW - 1) % NW) + 8 + (s - 8);
        else if (s < 24) return 8 + 16 * w + (s - 16);
        else             return 8 + 16 * w + 8 + (s - 24);
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int s, input logic [DW-1:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_spec = 5'(s); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        model[bmap(bw, s)] = v;
    endtask

    task automatic step(input logic sv, input logic rs, input logic [NW-1:0] m);
        @(negedge clk);
        save_req = sv; restore_req = rs; inval_mask = m;
        @(negedge clk);
        save_req = 1'b0; restore_req = 1'b0;
    endtask

    task automatic rd(input int s, input string tag);
        rs_a = 5'(s); rs_b = 5'(31 - s);
        #1;
        chk(tag, rd_a, model[bmap(bw, s)]);
        chk(tag, rd_b, model[bmap(bw, 31 - s)]);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NPH; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 cur_win", DW'(cur_win), 0);
        chk("R1 ovf", DW'(ovf_trap), 0);
        chk("R1 unf", DW'(unf_trap), 0);
        for (int s = 0; s < 32; s++) rd(s, "R1 zero");

        // Fill every specifier of every window
        for (int w = 0; w < NW; w++) begin
            for (int s = 0; s < 32; s++) wr(s, {8'(w), 8'(s), 16'hA5C3});
            step(1'b1, 1'b0, '0);
            bw = (bw + 1) % NW;
        end
        // R5 wrap after a full ring of saves
        chk("R5 wrap", DW'(cur_win), 0);

        // R2 R3 R4 readback around the ring
        for (int w = 0; w < NW; w++) begin
            for (int s = 0; s < 32; s++) rd(s, "R2/R3/R4 sweep");
            step(1'b1, 1'b0, '0);
            bw = (bw + 1) % NW;
        end

        // R4 explicit wrap: window 0 incoming equals last window outgoing
        rs_a = 5'd8; #1;
        chk("R4 ring wrap", rd_a, {8'(NW - 1), 8'd24, 16'hA5C3});

        // R6 restore from 0 wraps to NW-1
        step(1'b0, 1'b1, '0); bw = NW - 1;
        chk("R6 restore wrap", DW'(cur_win), NW - 1);
        step(1'b1, 1'b0, '0); bw = 0;
        chk("R5 save", DW'(cur_win), 0);

        // R2 global written in window 0, seen in window 1
        wr(5, 32'h0000_6105);
        step(1'b1, 1'b0, '0); bw = 1;
        rs_a = 5'd5; #1;
        chk("R2 global", rd_a, 32'h0000_6105);
        // R3 local written in window 1 leaves window 0 unchanged
        wr(18, 32'h1111_0018);
        step(1'b0, 1'b1, '0); bw = 0;
        rs_a = 5'd18; #1;
        chk("R3 private", rd_a, {8'd0, 8'd18, 16'hA5C3});

        // R7 save into masked window
        step(1'b1, 1'b0, NW'(2));
        chk("R7 ovf", DW'(ovf_trap), 1);
        chk("R7 hold", DW'(cur_win), 0);
        @(negedge clk);
        chk("R7 pulse", DW'(ovf_trap), 0);
        // R8 restore into masked window
        step(1'b0, 1'b1, NW'(1 << (NW - 1)));
        chk("R8 unf", DW'(unf_trap), 1);
        chk("R8 ovf low", DW'(ovf_trap), 0);
        chk("R8 hold", DW'(cur_win), 0);
        @(negedge clk);
        chk("R8 pulse", DW'(unf_trap), 0);
        inval_mask = '0;

        // R9 save and restore together act as save
        step(1'b1, 1'b1, '0); bw = 1;
        chk("R9 save wins", DW'(cur_win), 1);
        chk("R9 no unf", DW'(unf_trap), 0);

        // R11 write in the same cycle as a save lands in the old window
        @(negedge clk);
        wr_en = 1'b1; wr_spec = 5'd24; wr_data = 32'hC0DE_0024; save_req = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; save_req = 1'b0;
        model[bmap(1, 24)] = 32'hC0DE_0024; bw = 2;
        chk("R11 window", DW'(cur_win), 2);
        rs_a = 5'd8; rs_b = 5'd24; #1;
        chk("R11 incoming", rd_a, 32'hC0DE_0024);
        chk("R11 own out", rd_b, model[bmap(2, 24)]);

        // R10 combinational bypass
        @(negedge clk);
        wr_en = 1'b1; wr_spec = 5'd17; wr_data = 32'hB1B1_0017;
        rs_a = 5'd17; rs_b = 5'd16; #1;
        chk("R10 bypass", rd_a, 32'hB1B1_0017);
        chk("R10 other port", rd_b, model[bmap(2, 16)]);
        @(negedge clk);
        wr_en = 1'b0;
        model[bmap(2, 17)] = 32'hB1B1_0017;
        #1;
        chk("R10 stored", rd_a, 32'hB1B1_0017);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule